// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device-side end of the serial link of a flash memory. The host selects the device by pulling chip select low and sends bytes most significant bit first. The first byte is the opcode. For an erase command, three address bytes follow. The block decides at the end of each frame whether an internal operation is launched.

It keeps the write-enable latch and answers status reads on the serial output. It also turns accepted erase commands into a one-cycle request. The request carries a size code and an address aligned down to the erased block. The erase engine outside the block reports its activity on the `busy` input.

The serial pins are asynchronous to the system clock. They pass through a synchronizer and are oversampled, so each SCK phase must last several system clock cycles.

Top module: `spi_flash_cmd_front`

## Requirements
- R1: SI is taken on rising SCK edges and SO changes only after falling SCK edges. Both SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) frames are handled.
- R2: The first 8 bits of a frame form the opcode. Erase commands then take three address bytes, most significant byte first. Only the low 20 address bits are kept; bits 23..20 are ignored.
- R3: Erase opcodes select the size code on `erase_size`: 20h gives code 0 (4 KB), 52h gives code 1 (32 KB) and D8h gives code 2 (64 KB). An accepted erase gives one `erase_req` pulse of one clock cycle, shortly after chip select rises.
- R4: On an accepted erase, `erase_addr` holds the received A19..A0 with the low bits forced to zero: 12 bits for code 0, 15 bits for code 1 and 16 bits for code 2.
- R5: An erase is accepted only if the write-enable latch is set when the frame ends. Accepting an erase clears the latch.
- R6: Whole bytes sent after the three address bytes are ignored, and the erase is still accepted.
- R7: If chip select rises after the address but not on a multiple of 8 bits, the erase is dropped and the write-enable latch is left unchanged.
- R8: If chip select rises before the opcode and all three address bytes are complete, nothing is issued and the latch is left unchanged.
- R9: After an unsupported opcode, the rest of the frame is ignored, even bytes that equal valid opcodes.
- R10: Opcode 06h sets the write-enable latch and opcode 04h clears it. Either takes effect only if chip select rises on a byte boundary.
- R11: Opcode 05h makes SO return the status byte, with bit 0 = `busy` and bit 1 = write-enable latch and other bits zero. The byte repeats while chip select stays low, and each repeat is sampled afresh.
- R12: `so_oe` is high only while a status byte is being returned. It is low while chip select is high and during every other command.
- R13: An erase whose frame ends while `busy` is high is not issued, and the latch stays set.
- R14: After reset, `erase_req` and `so_oe` are low and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sck | input | 1 | Serial clock from host, asynchronous |
| si | input | 1 | Serial data from host |
| busy | input | 1 | Erase/program engine activity |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for SO (low = high impedance) |
| erase_req | output | 1 | One-cycle erase launch pulse |
| erase_size | output | 2 | Erase size code (0: 4 KB, 1: 32 KB, 2: 64 KB) |
| erase_addr | output | ADDR_W | Block-aligned erase start address |

## Verification
The write-enable latch can only be seen through a status read. The bench therefore follows each command that could move the latch with a status read. A latch that is wrongly set or cleared shows up at the next status byte, or as an extra or missing erase pulse at the end of the next erase frame.

A bit counter that is off by one shows in two ways. A misaligned address appears on `erase_addr` within a few cycles of chip select rising. Or the boundary check goes wrong, and a frame that should be dropped issues an erase, or the reverse.

A scoreboard matches every `erase_req` pulse against the queue of expected erases. An unexpected pulse is reported at once.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    ERS_4K  = 2'd0,
    ERS_32K = 2'd1,
    ERS_64K = 2'd2
  } ers_size_e;

  typedef enum logic [2:0] {
    ST_OPC,    // collecting opcode
    ST_ADR,    // collecting erase address bytes
    ST_TAIL,   // address complete, waiting for frame end
    ST_SETWE,  // latch-set opcode received
    ST_CLRWE,  // latch-clear opcode received
    ST_STAT,   // returning status bytes
    ST_DROP    // unsupported opcode, ignore to frame end
  } cmd_st_e;

  localparam logic [7:0] OPC_ERS_4K  = 8'h20;
  localparam logic [7:0] OPC_ERS_32K = 8'h52;
  localparam logic [7:0] OPC_ERS_64K = 8'hD8;
  localparam logic [7:0] OPC_RD_STAT = 8'h05;
  localparam logic [7:0] OPC_WE_CLR  = 8'h04;
  localparam logic [7:0] OPC_WE_SET  = 8'h06;

  localparam int unsigned ADR_BYTES = 3;

  // number of low address bits cleared for each erase size
  function automatic int unsigned ers_span_bits(ers_size_e s);
    case (s)
      ERS_4K:  return 12;
      ERS_32K: return 15;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int unsigned       W       = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[i]}};
      else     pipe <= {pipe[STAGES-2:0], d_in[i]};
    end
    assign q[i] = pipe[STAGES-1];
  end

endmodule

// File: rtl/sfc_bit_rx.sv
module sfc_bit_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_on,
  input  logic       sck_rise,
  input  logic       si_s,
  output logic [2:0] bit_cnt,
  output logic       byte_done,
  output logic [7:0] byte_val
);

  logic [6:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !frame_on) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      sh      <= {sh[5:0], si_s};
    end
  end

  assign byte_done = frame_on && sck_rise && (bit_cnt == 3'd7);
  assign byte_val  = {sh, si_s};

endmodule

// File: rtl/sfc_bit_tx.sv
module sfc_bit_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_on,
  input  logic       active,
  input  logic       sck_fall,
  input  logic [7:0] stat_byte,
  output logic       so,
  output logic       so_oe
);

  logic [2:0] out_cnt;
  logic [7:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !frame_on) begin
      out_cnt <= '0;
      sh      <= '0;
      so      <= 1'b0;
      so_oe   <= 1'b0;
    end else if (active && sck_fall) begin
      so_oe   <= 1'b1;
      out_cnt <= out_cnt + 3'd1;
      if (out_cnt == 3'd0) begin
        so <= stat_byte[7];
        sh <= {stat_byte[6:0], 1'b0};
      end else begin
        so <= sh[7];
        sh <= {sh[6:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/sfc_cmd_ctl.sv
module sfc_cmd_ctl
  import sfc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_on,
  input  logic              frame_end,
  input  logic [2:0]        bit_cnt,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic              busy,
  output logic              stat_sel,
  output logic              wel,
  output logic              ers_req,
  output ers_size_e         ers_size,
  output logic [ADDR_W-1:0] ers_addr
);

  localparam int unsigned CNT_W = $clog2(ADR_BYTES + 1);

  cmd_st_e          state;
  ers_size_e        pend_sz;
  logic [CNT_W-1:0] adr_cnt;
  logic [ADDR_W-1:0] adr_sh;
  logic             on_boundary;

  assign on_boundary = (bit_cnt == 3'd0);
  assign stat_sel    = (state == ST_STAT);

  function automatic logic [ADDR_W-1:0] blk_base(logic [ADDR_W-1:0] a, ers_size_e s);
    return a & ({ADDR_W{1'b1}} << ers_span_bits(s));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OPC;
      pend_sz  <= ERS_4K;
      adr_cnt  <= '0;
      adr_sh   <= '0;
      wel      <= 1'b0;
      ers_req  <= 1'b0;
      ers_size <= ERS_4K;
      ers_addr <= '0;
    end else begin
      ers_req <= 1'b0;
      if (frame_end) begin
        case (state)
          ST_TAIL: begin
            if (on_boundary && wel && !busy) begin
              ers_req  <= 1'b1;
              ers_size <= pend_sz;
              ers_addr <= blk_base(adr_sh, pend_sz);
              wel      <= 1'b0;
            end
          end
          ST_SETWE: if (on_boundary) wel <= 1'b1;
          ST_CLRWE: if (on_boundary) wel <= 1'b0;
          default: ;
        endcase
        state   <= ST_OPC;
        adr_cnt <= '0;
      end else if (!frame_on) begin
        state   <= ST_OPC;
        adr_cnt <= '0;
      end else if (byte_done) begin
        case (state)
          ST_OPC: begin
            case (byte_val)
              OPC_ERS_4K:  begin state <= ST_ADR; pend_sz <= ERS_4K;  end
              OPC_ERS_32K: begin state <= ST_ADR; pend_sz <= ERS_32K; end
              OPC_ERS_64K: begin state <= ST_ADR; pend_sz <= ERS_64K; end
              OPC_WE_SET:  state <= ST_SETWE;
              OPC_WE_CLR:  state <= ST_CLRWE;
              OPC_RD_STAT: state <= ST_STAT;
              default:     state <= ST_DROP;
            endcase
          end
          ST_ADR: begin
            adr_sh  <= {adr_sh[ADDR_W-9:0], byte_val};
            adr_cnt <= adr_cnt + 1'b1;
            if (adr_cnt == CNT_W'(ADR_BYTES - 1)) state <= ST_TAIL;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_flash_cmd_front.sv
module spi_flash_cmd_front
  import sfc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              busy,
  output logic              so,
  output logic              so_oe,
  output logic              erase_req,
  output logic [1:0]        erase_size,
  output logic [ADDR_W-1:0] erase_addr
);

  logic [2:0] pin_q;
  logic       cs_q, sck_q, si_q;
  logic       cs_d, sck_d;
  logic       frame_on, frame_end, sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic       byte_done;
  logic [7:0] byte_val;
  logic       stat_sel;
  logic       wel_q;
  ers_size_e  ers_size;
  logic [7:0] stat_byte;

  sfc_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_in({cs_n, sck, si}),
    .q   (pin_q)
  );

  assign {cs_q, sck_q, si_q} = pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_q;
      sck_d <= sck_q;
    end
  end

  assign frame_on  = !cs_q;
  assign frame_end = cs_q && !cs_d;
  assign sck_rise  = sck_q && !sck_d;
  assign sck_fall  = !sck_q && sck_d;

  sfc_bit_rx u_rx (
    .clk      (clk),
    .rst      (rst),
    .frame_on (frame_on),
    .sck_rise (sck_rise),
    .si_s     (si_q),
    .bit_cnt  (bit_cnt),
    .byte_done(byte_done),
    .byte_val (byte_val)
  );

  sfc_cmd_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .frame_on (frame_on),
    .frame_end(frame_end),
    .bit_cnt  (bit_cnt),
    .byte_done(byte_done),
    .byte_val (byte_val),
    .busy     (busy),
    .stat_sel (stat_sel),
    .wel      (wel_q),
    .ers_req  (erase_req),
    .ers_size (ers_size),
    .ers_addr (erase_addr)
  );

  assign erase_size = ers_size;
  assign stat_byte  = {6'b0, wel_q, busy};

  sfc_bit_tx u_tx (
    .clk      (clk),
    .rst      (rst),
    .frame_on (frame_on),
    .active   (stat_sel),
    .sck_fall (sck_fall),
    .stat_byte(stat_byte),
    .so       (so),
    .so_oe    (so_oe)
  );

endmodule

// File: rtl/sfc_front_chk.sv
module sfc_front_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              so_oe,
  input logic              erase_req,
  input logic [1:0]        erase_size,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              wel
);

  logic [2:0] cs_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cs_hi_cnt <= '0;
    else if (!cs_n)            cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 3'd1;
  end

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    erase_req |=> !erase_req);

  p_size_legal_r3: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> (erase_size != 2'd3));

  p_align_4k_r4: assert property (@(posedge clk) disable iff (rst)
    (erase_req && erase_size == 2'd0) |-> (erase_addr[11:0] == '0));

  p_align_32k_r4: assert property (@(posedge clk) disable iff (rst)
    (erase_req && erase_size == 2'd1) |-> (erase_addr[14:0] == '0));

  p_align_64k_r4: assert property (@(posedge clk) disable iff (rst)
    (erase_req && erase_size == 2'd2) |-> (erase_addr[15:0] == '0));

  p_wel_consumed_r5: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> ($past(wel) && !wel));

  p_hiz_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt >= 3'd4) |-> !so_oe);

endmodule

bind spi_flash_cmd_front sfc_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .so_oe     (so_oe),
  .erase_req (erase_req),
  .erase_size(erase_size),
  .erase_addr(erase_addr),
  .wel       (wel_q)
);

// File: tb/sim_spi_flash_cmd_front.sv
module sim_spi_flash_cmd_front;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned HALF   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic busy = 1'b0;
  logic so, so_oe, erase_req;
  logic [1:0] erase_size;
  logic [ADDR_W-1:0] erase_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mode3 = 1'b0;

  typedef struct packed {
    logic [1:0]        sz;
    logic [ADDR_W-1:0] a;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  spi_flash_cmd_front #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
    .so(so), .so_oe(so_oe), .erase_req(erase_req),
    .erase_size(erase_size), .erase_addr(erase_addr)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open();
    sck = mode3;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    sck = 1'b0;
    si  = b;
    wait_clk(HALF);
    r   = so;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic frame_close();
    if (!mode3) sck = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  // opcode, nadr address bytes, extra whole bytes, extra loose bits
  task automatic cmd(input logic [7:0] op, input int nadr, input logic [23:0] adr,
                     input int extra_bytes, input int extra_bits);
    logic [7:0] rx;
    logic b;
    frame_open();
    xfer_byte(op, rx);
    for (int k = 0; k < nadr; k++) xfer_byte(adr[23-8*k -: 8], rx);
    for (int k = 0; k < extra_bytes; k++) xfer_byte(8'h5A, rx);
    for (int k = 0; k < extra_bits; k++) xfer_bit(1'b1, b);
    frame_close();
  endtask

  task automatic rd_status(input logic [7:0] exp, input string req);
    logic [7:0] rx;
    frame_open();
    xfer_byte(8'h05, rx);
    xfer_byte(8'h00, rx);
    chk(rx === exp, req, {24'b0, rx}, {24'b0, exp});
    chk(so_oe === 1'b1, "R12 so_oe during status", {31'b0, so_oe}, 32'd1);
    frame_close();
    chk(so_oe === 1'b0, "R12 so_oe after frame", {31'b0, so_oe}, 32'd0);
  endtask

  task automatic expect_erase(input logic [1:0] sz, input logic [ADDR_W-1:0] a);
    exp_t e;
    e.sz = sz;
    e.a  = a;
    exp_q.push_back(e);
  endtask

  task automatic drain_check(input string req);
    wait_clk(4);
    chk(exp_q.size() == 0, req, exp_q.size(), 32'd0);
  endtask

  // monitor: every erase pulse must match the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && erase_req === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected erase", {10'b0, erase_size, erase_addr}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(erase_size === e.sz && erase_addr === e.a, "R3 R4 erase size/address",
              {10'b0, erase_size, erase_addr}, {10'b0, e.sz, e.a});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_up();
  end

  initial begin
    logic [7:0] rx;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R14 reset state
    chk(so_oe === 1'b0, "R14 so_oe after reset", {31'b0, so_oe}, 32'd0);
    chk(erase_req === 1'b0, "R14 erase_req after reset", {31'b0, erase_req}, 32'd0);
    rd_status(8'h00, "R14 latch clear after reset");

    // R11 busy reflected, repeated reads sample afresh
    busy = 1'b1;
    rd_status(8'h01, "R11 status with busy");
    frame_open();
    xfer_byte(8'h05, rx);
    xfer_byte(8'h00, rx);
    chk(rx === 8'h01, "R11 repeat byte 1", {24'b0, rx}, 32'h01);
    busy = 1'b0;
    xfer_byte(8'h00, rx);
    chk(rx === 8'h00, "R11 repeat byte 2", {24'b0, rx}, 32'h00);
    frame_close();

    // R10 latch set, R12 no drive during non-status command
    frame_open();
    xfer_byte(8'h06, rx);
    chk(so_oe === 1'b0, "R12 so_oe during set-latch frame", {31'b0, so_oe}, 32'd0);
    frame_close();
    rd_status(8'h02, "R10 latch set by 06h");

    // R2 R3 R4 R5 4 KB erase, top nibble ignored
    expect_erase(2'd0, 20'h12000);
    cmd(8'h20, 3, 24'hF12345, 0, 0);
    drain_check("R3 4KB erase issued");
    rd_status(8'h00, "R5 latch cleared by erase");

    // R5 erase without latch
    cmd(8'h20, 3, 24'h012345, 0, 0);
    drain_check("R5 no erase without latch");

    // R1 mode 3, 32 KB erase
    mode3 = 1'b1;
    cmd(8'h06, 0, 24'h0, 0, 0);
    rd_status(8'h02, "R1 mode 3 status read");
    expect_erase(2'd1, 20'hA8000);
    cmd(8'h52, 3, 24'h0ABCDE, 0, 0);
    drain_check("R1 mode 3 32KB erase");
    mode3 = 1'b0;

    // R6 64 KB with extra bytes
    cmd(8'h06, 0, 24'h0, 0, 0);
    expect_erase(2'd2, 20'hF0000);
    cmd(8'hD8, 3, 24'h7FFFFF, 2, 0);
    drain_check("R6 64KB erase with trailing bytes");

    // R7 off-boundary abort
    cmd(8'h06, 0, 24'h0, 0, 0);
    cmd(8'h20, 3, 24'h000123, 0, 3);
    drain_check("R7 off-boundary erase dropped");
    rd_status(8'h02, "R7 latch kept after abort");

    // R8 short address
    cmd(8'h20, 2, 24'h123400, 0, 0);
    drain_check("R8 short address dropped");
    cmd(8'h20, 0, 24'h0, 0, 5);
    drain_check("R8 partial frame dropped");
    rd_status(8'h02, "R8 latch kept");

    // R9 unsupported opcode followed by clear-latch byte
    cmd(8'hAB, 0, 24'h0, 0, 0);
    cmd(8'h9F, 0, 24'h040404, 0, 0);
    frame_open();
    xfer_byte(8'h9F, rx);
    xfer_byte(8'h04, rx);
    frame_close();
    rd_status(8'h02, "R9 unsupported opcode ignored");

    // R13 erase refused while busy
    busy = 1'b1;
    cmd(8'h20, 3, 24'h055555, 0, 0);
    drain_check("R13 no erase while busy");
    busy = 1'b0;
    rd_status(8'h02, "R13 latch kept while busy");

    // R10 clear, and off-boundary set ignored
    cmd(8'h04, 0, 24'h0, 0, 0);
    rd_status(8'h00, "R10 latch cleared by 04h");
    cmd(8'h06, 0, 24'h0, 0, 3);
    rd_status(8'h00, "R10 off-boundary set ignored");

    wait_clk(20);
    chk(exp_q.size() == 0, "R3 final queue empty", exp_q.size(), 32'd0);
    finish_up();
  end

endmodule